// File: doc/BRIEF.md
# Self-Checking Execute ALU with Spare Result Path

This block is the arithmetic and logic unit of a processor execute stage that watches its own correctness. It carries out six bitwise operations, modular addition and subtraction, and three kinds of shift on two operands. A second copy of the datapath works on the same inputs. The parity of its result is compared with the parity of the primary result. The parity of each operand is also compared with a parity bit that comes with that operand. Any mismatch raises a registered error flag. A surrounding controller can use this flag to stall the pipeline and decide whether the fault is lasting.

To recover from a lasting fault, the block exports its operands and operation code to an external replacement unit at all times. A select input then routes the replacement unit's result to the output in place of the internal one. While that path is selected, the internal checker is silenced, so a broken internal unit raises no further alarms.

A test input XORs a mask into the primary result only. This lets a bench force detected errors, or show that some faults escape detection.

Top module: `salu_top`

## Requirements
- R1: Operation codes 0 to 5 give, in order, a AND b, NOT(a AND b), a OR b, NOT(a OR b), a XOR b, NOT(a XOR b).
- R2: Code 6 gives a + b and code 7 gives a - b, both taken modulo 2^32.
- R3: Code 8 shifts a left logically, code 9 shifts it right logically, and code 10 shifts it right arithmetically. In each case the shift amount is op_b[4:0].
- R4: Codes 11 to 15 give a result of zero.
- R5: The result and the error flag are registered. They show the effect of the inputs one clock edge after those inputs are applied, and both are zero during and straight after reset.
- R6: When the internal result is selected, inj_mask is XORed into the result. A mask with an odd number of set bits raises err_o.
- R7: A nonzero mask with an even number of set bits corrupts the result but does not raise err_o, because parity cannot see an even number of flipped bits.
- R8: a_par must equal the XOR of all bits of op_a, and b_par the XOR of all bits of op_b. Either mismatch raises err_o while the internal result is selected.
- R9: With use_spare at 1, the registered result equals spare_res, and inj_mask has no effect on it.
- R10: With use_spare at 1, err_o stays 0 whatever the operand parity bits or the mask.
- R11: spare_a, spare_b and spare_op equal op_a, op_b and opcode in the same cycle, whatever the value of use_spare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; bits 4:0 give the shift amount |
| a_par | input | 1 | Parity bit sent with op_a |
| b_par | input | 1 | Parity bit sent with op_b |
| opcode | input | 4 | Operation code |
| use_spare | input | 1 | 1 routes the replacement unit's result to the output |
| spare_res | input | 32 | Result from the external replacement unit |
| inj_mask | input | 32 | Fault mask XORed into the primary result |
| spare_a | output | 32 | op_a, exported to the replacement unit |
| spare_b | output | 32 | op_b, exported to the replacement unit |
| spare_op | output | 4 | opcode, exported to the replacement unit |
| res_o | output | 32 | Registered result |
| err_o | output | 1 | Registered error flag |

## Verification
The bound checker runs on every cycle. It checks that the spare path is followed and keeps the flag quiet. It checks that an odd mask or a bad operand parity bit always raises the flag, and that clean inputs never do. It also checks the AND and ADD results against the operands of the previous cycle. Only the bench's scenarios cover the rest: every operation code, including the shift extremes (amounts 0 and 31, and arithmetic shift of a negative value), wrap-around in addition and subtraction, and the unused codes. The same holds for the escape of even-weight masks, the reset values, and the one-cycle latency.

// File: rtl/salu_pkg.sv
package salu_pkg;
   localparam int OPW = 4;

   typedef enum logic [OPW-1:0] {
      OP_AND  = 4'd0,
      OP_NAND = 4'd1,
      OP_OR   = 4'd2,
      OP_NOR  = 4'd3,
      OP_XOR  = 4'd4,
      OP_XNOR = 4'd5,
      OP_ADD  = 4'd6,
      OP_SUB  = 4'd7,
      OP_SLL  = 4'd8,
      OP_SRL  = 4'd9,
      OP_SRA  = 4'd10
   } alu_op_e;
endpackage

// File: rtl/salu_core.sv
module salu_core #(
   parameter int W = 32
) (
   input  logic [W-1:0]             a,
   input  logic [W-1:0]             b,
   input  logic [salu_pkg::OPW-1:0] op,
   output logic [W-1:0]             y
);
   import salu_pkg::*;
   localparam int SHW = $clog2(W);

   if (W < 2 || (1 << SHW) != W) begin : g_bad_width
      $error("salu_core: W must be a power of two, at least 2");
   end

   logic [SHW-1:0] amt;
   assign amt = b[SHW-1:0];

   always_comb begin
      case (alu_op_e'(op))
         OP_AND:  y = a & b;
         OP_NAND: y = ~(a & b);
         OP_OR:   y = a | b;
         OP_NOR:  y = ~(a | b);
         OP_XOR:  y = a ^ b;
         OP_XNOR: y = ~(a ^ b);
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_SLL:  y = a << amt;
         OP_SRL:  y = a >> amt;
         OP_SRA:  y = W'($signed(a) >>> amt);
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/salu_parity.sv
module salu_parity #(
   parameter int W     = 32,
   parameter int GROUP = 8
) (
   input  logic [W-1:0] d,
   output logic         p
);
   if (GROUP < 1 || (GROUP < W && (W % GROUP) != 0)) begin : g_bad_group
      $error("salu_parity: GROUP must divide W");
   end

   if (GROUP >= W) begin : g_flat
      assign p = ^d;
   end else begin : g_tree
      localparam int NG = W / GROUP;
      logic [NG-1:0] part;
      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign part[g] = ^d[g*GROUP +: GROUP];
      end
      assign p = ^part;
   end
endmodule

// File: rtl/salu_select.sv
module salu_select #(
   parameter int W = 32
) (
   input  logic         sel_ext,
   input  logic [W-1:0] int_res,
   input  logic [W-1:0] ext_res,
   output logic [W-1:0] y
);
   assign y = sel_ext ? ext_res : int_res;
endmodule

// File: rtl/salu_top.sv
module salu_top #(
   parameter int W         = 32,
   parameter int PAR_GROUP = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [W-1:0]             op_a,
   input  logic [W-1:0]             op_b,
   input  logic                     a_par,
   input  logic                     b_par,
   input  logic [salu_pkg::OPW-1:0] opcode,
   input  logic                     use_spare,
   input  logic [W-1:0]             spare_res,
   input  logic [W-1:0]             inj_mask,
   output logic [W-1:0]             spare_a,
   output logic [W-1:0]             spare_b,
   output logic [salu_pkg::OPW-1:0] spare_op,
   output logic [W-1:0]             res_o,
   output logic                     err_o
);
   logic [W-1:0] pri_raw, pri_res, sha_res, sel_res;
   logic         p_pri, p_sha, p_a, p_b, err_next;

   // Export to the replacement unit, unconditionally
   assign spare_a  = op_a;
   assign spare_b  = op_b;
   assign spare_op = opcode;

   salu_core #(.W(W)) i_primary (.a(op_a), .b(op_b), .op(opcode), .y(pri_raw));
   salu_core #(.W(W)) i_shadow  (.a(op_a), .b(op_b), .op(opcode), .y(sha_res));

   assign pri_res = pri_raw ^ inj_mask;

   salu_parity #(.W(W), .GROUP(PAR_GROUP)) i_par_pri (.d(pri_res), .p(p_pri));
   salu_parity #(.W(W), .GROUP(PAR_GROUP)) i_par_sha (.d(sha_res), .p(p_sha));
   salu_parity #(.W(W), .GROUP(PAR_GROUP)) i_par_a   (.d(op_a),    .p(p_a));
   salu_parity #(.W(W), .GROUP(PAR_GROUP)) i_par_b   (.d(op_b),    .p(p_b));

   salu_select #(.W(W)) i_sel (
      .sel_ext (use_spare),
      .int_res (pri_res),
      .ext_res (spare_res),
      .y       (sel_res)
   );

   assign err_next = !use_spare && ((p_pri ^ p_sha) || (p_a ^ a_par) || (p_b ^ b_par));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o <= '0;
         err_o <= 1'b0;
      end else begin
         res_o <= sel_res;
         err_o <= err_next;
      end
   end
endmodule

// File: rtl/salu_chk.sv
module salu_chk #(
   parameter int W = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [W-1:0]             op_a,
   input logic [W-1:0]             op_b,
   input logic                     a_par,
   input logic                     b_par,
   input logic [salu_pkg::OPW-1:0] opcode,
   input logic                     use_spare,
   input logic [W-1:0]             spare_res,
   input logic [W-1:0]             inj_mask,
   input logic [W-1:0]             spare_a,
   input logic [W-1:0]             spare_b,
   input logic [salu_pkg::OPW-1:0] spare_op,
   input logic [W-1:0]             res_o,
   input logic                     err_o
);
   logic clean;
   assign clean = !use_spare && (inj_mask == '0) && (a_par == ^op_a) && (b_par == ^op_b);

   // R9
   spare_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      use_spare |=> res_o == $past(spare_res));

   // R10
   spare_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      use_spare |=> !err_o);

   // R6
   odd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_spare && (^inj_mask)) |=> err_o);

   // R8
   opnd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_spare && ((a_par != ^op_a) || (b_par != ^op_b))) |=> err_o);

   // R5
   no_false_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clean |=> !err_o);

   // R1
   and_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clean && opcode == 4'd0) |=> res_o == $past(op_a & op_b));

   // R2
   add_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clean && opcode == 4'd6) |=> res_o == $past(op_a + op_b));
endmodule

bind salu_top salu_chk #(.W(W)) i_chk (.*);

// File: tb/test_salu_top.sv
module test_salu_top;
   localparam int W = 32;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [W-1:0]  op_a = 0, op_b = 0, spare_res = 0, inj_mask = 0;
   logic          a_par = 0, b_par = 0, use_spare = 0;
   logic [3:0]    opcode = 0;
   logic [W-1:0]  spare_a, spare_b, res_o;
   logic [3:0]    spare_op;
   logic          err_o;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   salu_top i_salu_top (.*);

   // expectation for the stimulus most recently driven
   logic [W-1:0] exp_res = 0;
   logic         exp_err = 0;
   string        res_tag = "R5", err_tag = "R5";

   function automatic logic [W-1:0] ref_alu(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
      int sh = int'(b[4:0]);
      longint sa = longint'($signed(a));
      case (op)
         0: return a & b;
         1: return ~(a & b);
         2: return a | b;
         3: return ~(a | b);
         4: return a ^ b;
         5: return ~(a ^ b);
         6: return W'(longint'(a) + longint'(b));
         7: return W'(longint'(a) - longint'(b));
         8: return W'(longint'(a) << sh);
         9: return a >> sh;
         10: return W'(sa >>> sh);
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Checks the previous step's outputs, then applies the new inputs.
   task automatic step(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit bad_pa, input bit bad_pb, input bit spare,
                       input logic [W-1:0] sres, input logic [W-1:0] inj);
      logic [W-1:0] held;
      @(negedge clk);
      chk(res_tag, res_o, exp_res);
      chk(err_tag, {31'b0, err_o}, {31'b0, exp_err});
      held = exp_res;
      op_a = a; op_b = b; opcode = 4'(op);
      a_par = (^a) ^ bad_pa; b_par = (^b) ^ bad_pb;
      use_spare = spare; spare_res = sres; inj_mask = inj;
      #1;
      chk("R11", spare_a, a);
      chk("R11", spare_b, b);
      chk("R11", {28'b0, spare_op}, {28'b0, 4'(op)});
      chk("R5 latency", res_o, held);
      // expectation from the requirements
      if (spare) begin
         exp_res = sres; exp_err = 0; res_tag = "R9"; err_tag = "R10";
      end else begin
         exp_res = ref_alu(op, a, b) ^ inj;
         exp_err = (^inj) | bad_pa | bad_pb;
         if (inj != 0) res_tag = (^inj) ? "R6" : "R7";
         else if (op <= 5) res_tag = "R1";
         else if (op <= 7) res_tag = "R2";
         else if (op <= 10) res_tag = "R3";
         else res_tag = "R4";
         if (^inj) err_tag = "R6";
         else if (bad_pa | bad_pb) err_tag = "R8";
         else if (inj != 0) err_tag = "R7";
         else err_tag = "R8 clean";
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 reset", res_o, '0);
      chk("R5 reset", {31'b0, err_o}, 32'b0);
      rst_n = 1;
      // R1 logic codes
      for (int op = 0; op < 6; op++) begin
         step(op, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 0, 0);
         step(op, 32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 0, 0, 0);
      end
      // R2 wrap-around
      step(6, 32'hFFFF_FFFF, 32'h0000_0002, 0, 0, 0, 0, 0);
      step(6, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0);
      step(7, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, 0, 0);
      step(7, 32'h0000_1000, 32'h0000_0FFF, 0, 0, 0, 0, 0);
      // R3 shifts, amount from low five bits
      step(8, 32'h8000_0001, 32'd0, 0, 0, 0, 0, 0);
      step(8, 32'h0000_0003, 32'd31, 0, 0, 0, 0, 0);
      step(9, 32'h8000_0000, 32'd31, 0, 0, 0, 0, 0);
      step(9, 32'hF000_000F, 32'hFFFF_FFE4, 0, 0, 0, 0, 0);
      step(10, 32'h8000_0000, 32'd31, 0, 0, 0, 0, 0);
      step(10, 32'h9000_0000, 32'd4, 0, 0, 0, 0, 0);
      step(10, 32'h7000_0000, 32'd4, 0, 0, 0, 0, 0);
      // R4 unused codes
      for (int op = 11; op < 16; op++) step(op, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, 0, 0);
      // R6 odd masks, R7 even masks
      step(6, 32'd5, 32'd7, 0, 0, 0, 0, 32'h0000_0001);
      step(4, 32'hAAAA_5555, 32'h1, 0, 0, 0, 0, 32'h8000_0007);
      step(6, 32'd5, 32'd7, 0, 0, 0, 0, 32'h0000_0003);
      step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 32'h8000_0001);
      step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 32'h0);
      // R8 bad operand parity
      step(2, 32'h0000_00F1, 32'h0, 1, 0, 0, 0, 0);
      step(2, 32'h0, 32'h0001_0000, 0, 1, 0, 0, 0);
      step(2, 32'h1, 32'h1, 1, 1, 0, 0, 0);
      // R9 / R10 spare path, mask and bad parity ignored
      step(6, 32'd1, 32'd2, 0, 0, 1, 32'hCAFE_F00D, 32'h0000_0001);
      step(7, 32'd9, 32'd2, 1, 1, 1, 32'h0000_0000, 32'hFFFF_FFFE);
      step(3, 32'd9, 32'd2, 0, 0, 1, 32'h1357_9BDF, 0);
      step(3, 32'd9, 32'd2, 0, 0, 0, 32'h1357_9BDF, 0);
      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom_range(0, 99));
         step(int'($urandom_range(0, 15)), $urandom, $urandom,
              r < 5, (r >= 5 && r < 10), (r >= 80),
              $urandom, (r >= 60 && r < 90) ? $urandom : 32'h0);
      end
      step(0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      chk(res_tag, res_o, exp_res);
      chk(err_tag, {31'b0, err_o}, {31'b0, exp_err});
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule